// File: doc/BRIEF.md
# LCD serial command/data receiver

This block is the serial front end of a small monochrome matrix LCD controller. It listens to a write-only link made of four lines: an active-low chip enable, a serial clock, a serial data line and a mode-select line. All four lines are brought into the system clock domain through synchronizers. The block then shifts bits in on rising edges of the serial clock, most significant bit first, and frames them into bytes.

Each completed byte is classed by the mode-select level seen on its eighth serial clock edge. A command byte raises a command strobe. A data byte becomes a display RAM write, at the address held by an X/Y counter that advances by itself. The display is 48 rows by 84 columns, held as 6 banks of 84 bytes. Command bytes that select a column (X) or a bank (Y) load the counter. Every byte is also reported on a one-cycle byte strobe, together with its value and a command/data flag.

Top module: `lcdrx_top`

## Requirements
- R1: Serial data is sampled on rising edges of `lcd_sclk` while `lcd_cen_n` is low. The first bit of a byte becomes bit 7 of `byte_data` and the eighth bit becomes bit 0.
- R2: The `lcd_dc` level sampled on the eighth rising edge decides the byte's class. A low level gives `cmd_stb`=1 and `byte_is_data`=0. A high level gives `ram_we`=1, `byte_is_data`=1 and `ram_wdata`=`byte_data`. Each completed byte pulses `byte_stb` once.
- R3: Outputs are registered. Suppose the eighth `lcd_sclk` rise is first present at the pin at `clk` edge k. Then `byte_stb`, `cmd_stb` or `ram_we` are high for exactly one cycle, from edge k+3 to edge k+4.
- R4: While `lcd_cen_n` is high, `lcd_sclk` pulses have no effect. Raising `lcd_cen_n` partway through a byte drops the partial byte with no strobe. The next byte after `lcd_cen_n` falls starts at bit 7.
- R5: While `lcd_cen_n` stays low, the rising edge that follows a completed byte is bit 7 of the next byte, with no gap.
- R6: A data byte is written at `ram_addr` = Y*84 + X. After the write, X increments. When X=83, X becomes 0 and Y advances to the next bank. From X=83, Y=5 the counter wraps to address 0.
- R7: A command byte of the form 1xxxxxxx loads X with its low 7 bits when that value is below 84. A command of the form 01000yyy loads Y with its low 3 bits when that value is below 6. Values out of range leave the counter unchanged. Both kinds still raise `cmd_stb`.
- R8: Synchronous active-high `rst` aborts any byte in progress, writes nothing, and clears X, Y and all outputs to 0.
- R9: If `lcd_cen_n` is low when `rst` is released, the next `lcd_sclk` rise is taken as bit 7 of a new byte.
- R10: The `lcd_dc` level on the first seven rising edges of a byte has no effect on its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_cen_n | input | 1 | Serial chip enable, active low |
| lcd_sclk | input | 1 | Serial clock |
| lcd_sdin | input | 1 | Serial data, MSB first |
| lcd_dc | input | 1 | Mode select: 0 command, 1 display data |
| byte_stb | output | 1 | One-cycle pulse per completed byte |
| byte_data | output | 8 | Value of the last completed byte |
| byte_is_data | output | 1 | Class of the last completed byte (1 = data) |
| cmd_stb | output | 1 | One-cycle pulse for a command byte |
| ram_we | output | 1 | One-cycle display RAM write enable |
| ram_addr | output | 9 | Display RAM write address, Y*84+X |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
A byte's strobes, value, class and write address are due in the fourth `clk` cycle after the bench drives the eighth serial clock rise. That is two synchronizer stages, one edge-detect and shift stage, and one output stage. The bench drives pins just after a falling `clk` edge. Whenever it drives an eighth rise, it queues the expected result tagged with the cycle count plus four. On every falling edge it compares the outputs: a strobe must appear exactly when an entry falls due, and never at other times. This also catches partial bytes, ignored pulses and reset aborts that wrongly emit a byte.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
  localparam int BYTE_W      = 8;
  localparam int SETX_BIT    = 7;
  localparam int SETY_PFX_W  = 5;
  localparam logic [SETY_PFX_W-1:0] SETY_PFX = 5'b01000;
endpackage

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk) begin
      if (rst) ff <= '0;
      else     ff <= {ff[STAGES-2:0], d[g]};
    end
    assign q[g] = ff[STAGES-1];
  end
endmodule

// File: rtl/lcdrx_shift.sv
module lcdrx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          cen_s,
  input  logic          sdin_s,
  input  logic          dc_s,
  output logic          vld,
  output logic [DW-1:0] bval,
  output logic          is_data
);
  localparam int CW = $clog2(DW);

  logic          sclk_d;
  logic [CW-1:0] cnt;
  logic [DW-2:0] sh;
  logic          rise;

  assign rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      vld     <= 1'b0;
      bval    <= '0;
      is_data <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      vld    <= 1'b0;
      if (cen_s) begin
        cnt <= '0;
      end else if (rise) begin
        if (cnt == CW'(DW-1)) begin
          bval    <= {sh, sdin_s};
          is_data <= dc_s;
          vld     <= 1'b1;
          cnt     <= '0;
        end else begin
          sh  <= {sh[DW-3:0], sdin_s};
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld); // R3
  AST_NO_BYTE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    cen_s |=> !vld); // R4
endmodule

// File: rtl/lcdrx_addr.sv
module lcdrx_addr
  import lcdrx_pkg::*;
#(
  parameter int COLS  = 84,
  parameter int BANKS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [BYTE_W-1:0] bval,
  input  logic              is_data,
  output logic              cmd_stb,
  output logic              ram_we,
  output logic [$clog2(COLS*BANKS)-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata
);
  localparam int DEPTH = COLS * BANKS;
  localparam int AW    = $clog2(DEPTH);
  localparam int XW    = SETX_BIT;
  localparam int YW    = BYTE_W - SETY_PFX_W;

  logic [XW-1:0] x;
  logic [YW-1:0] y;

  always_ff @(posedge clk) begin
    if (rst) begin
      x         <= '0;
      y         <= '0;
      cmd_stb   <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      cmd_stb <= vld & ~is_data;
      ram_we  <= vld & is_data;
      if (vld && is_data) begin
        ram_addr  <= AW'(int'(y) * COLS + int'(x));
        ram_wdata <= bval;
        if (x == XW'(COLS-1)) begin
          x <= '0;
          y <= (y == YW'(BANKS-1)) ? '0 : y + YW'(1);
        end else begin
          x <= x + XW'(1);
        end
      end else if (vld) begin
        if (bval[SETX_BIT]) begin
          if (int'(bval[XW-1:0]) < COLS) x <= bval[XW-1:0];
        end else if (bval[BYTE_W-1:YW] == SETY_PFX) begin
          if (int'(bval[YW-1:0]) < BANKS) y <= bval[YW-1:0];
        end
      end
    end
  end

  AST_X_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(x) < COLS); // R7
  AST_Y_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(y) < BANKS); // R7
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> int'(ram_addr) < DEPTH); // R6
  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && cmd_stb)); // R2
endmodule

// File: rtl/lcdrx_top.sv
module lcdrx_top
  import lcdrx_pkg::*;
#(
  parameter int COLS        = 84,
  parameter int BANKS       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lcd_cen_n,
  input  logic              lcd_sclk,
  input  logic              lcd_sdin,
  input  logic              lcd_dc,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_is_data,
  output logic              cmd_stb,
  output logic              ram_we,
  output logic [$clog2(COLS*BANKS)-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata
);
  logic [3:0]        pins_s;
  logic              sh_vld;
  logic [BYTE_W-1:0] sh_bval;
  logic              sh_is_data;

  lcdrx_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({lcd_dc, lcd_sdin, lcd_cen_n, lcd_sclk}),
    .q   (pins_s)
  );

  lcdrx_shift #(.DW(BYTE_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (pins_s[0]),
    .cen_s   (pins_s[1]),
    .sdin_s  (pins_s[2]),
    .dc_s    (pins_s[3]),
    .vld     (sh_vld),
    .bval    (sh_bval),
    .is_data (sh_is_data)
  );

  lcdrx_addr #(.COLS(COLS), .BANKS(BANKS)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .vld       (sh_vld),
    .bval      (sh_bval),
    .is_data   (sh_is_data),
    .cmd_stb   (cmd_stb),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_stb     <= 1'b0;
      byte_data    <= '0;
      byte_is_data <= 1'b0;
    end else begin
      byte_stb <= sh_vld;
      if (sh_vld) begin
        byte_data    <= sh_bval;
        byte_is_data <= sh_is_data;
      end
    end
  end

  AST_WE_MATCH: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (byte_stb && byte_is_data && ram_wdata == byte_data)); // R2
  AST_CMD_MATCH: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> (byte_stb && !byte_is_data)); // R2
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!byte_stb && !ram_we && !cmd_stb)); // R8
endmodule

// File: tb/lcdrx_top_tb.sv
module lcdrx_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lcd_cen_n = 1'b1, lcd_sclk = 1'b0, lcd_sdin = 1'b0, lcd_dc = 1'b0;
  logic       byte_stb, byte_is_data, cmd_stb, ram_we;
  logic [7:0] byte_data, ram_wdata;
  logic [8:0] ram_addr;

  lcdrx_top u_dut (
    .clk(clk), .rst(rst), .lcd_cen_n(lcd_cen_n), .lcd_sclk(lcd_sclk),
    .lcd_sdin(lcd_sdin), .lcd_dc(lcd_dc), .byte_stb(byte_stb),
    .byte_data(byte_data), .byte_is_data(byte_is_data), .cmd_stb(cmd_stb),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    due;
    int    b;
    bit    d;
    int    addr;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  int mx = 0, my = 0;

  function automatic void chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (q.size() > 0 && q[0].due == cyc) begin
      chk(byte_stb == 1'b1, q[0].tag, "byte_stb", int'(byte_stb), 1);
      chk(int'(byte_data) == q[0].b, q[0].tag, "byte_data", int'(byte_data), q[0].b);
      chk(byte_is_data == q[0].d, q[0].tag, "byte_is_data", int'(byte_is_data), int'(q[0].d));
      chk(cmd_stb == !q[0].d && ram_we == q[0].d, q[0].tag, "cmd_stb/ram_we",
          int'({cmd_stb, ram_we}), int'({!q[0].d, q[0].d}));
      if (q[0].d) begin
        chk(int'(ram_addr) == q[0].addr, q[0].tag, "ram_addr", int'(ram_addr), q[0].addr);
        chk(int'(ram_wdata) == q[0].b, q[0].tag, "ram_wdata", int'(ram_wdata), q[0].b);
      end
      void'(q.pop_front());
    end else if (byte_stb || cmd_stb || ram_we) begin
      chk(1'b0, "R3/R4", "unexpected strobe", int'({byte_stb, cmd_stb, ram_we}), 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_byte(int b, bit d, string tag);
    exp_t e;
    e.due = cyc + 4; e.b = b; e.d = d; e.tag = tag; e.addr = 0;
    if (d) begin
      e.addr = my * 84 + mx;
      if (mx == 83) begin mx = 0; my = (my == 5) ? 0 : my + 1; end
      else mx++;
    end else if (b[7]) begin
      if ((b & 127) < 84) mx = b & 127;
    end else if ((b >> 3) == 8) begin
      if ((b & 7) < 6) my = b & 7;
    end
    q.push_back(e);
  endtask

  task automatic send_bits(logic [7:0] b, int nbits, bit dc_other, bit dc_last, string tag);
    for (int i = 0; i < nbits; i++) begin
      lcd_sclk = 1'b0;
      lcd_sdin = b[7-i];
      lcd_dc   = (i == 7) ? dc_last : dc_other;
      step(3);
      lcd_sclk = 1'b1;
      if (i == 7) expect_byte(int'(b), dc_last, tag);
      step(3);
    end
    lcd_sclk = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, bit d, string tag);
    send_bits(b, 8, d, d, tag);
  endtask

  initial begin
    step(5);
    rst = 1'b0;
    step(2);
    chk(!byte_stb && !cmd_stb && !ram_we, "R8", "strobes after reset",
        int'({byte_stb, cmd_stb, ram_we}), 0);
    chk(ram_addr == 0 && byte_data == 0, "R8", "outputs after reset",
        int'(ram_addr) + int'(byte_data), 0);

    lcd_cen_n = 1'b0; step(4);
    send_byte(8'h8A, 1'b0, "R7 set X=10");
    send_byte(8'h42, 1'b0, "R7 set Y=2");
    send_byte(8'hA5, 1'b1, "R1 R5 data");
    send_byte(8'h3C, 1'b1, "R5 R6 data");

    send_byte(8'hD3, 1'b0, "R7 set X=83");
    send_byte(8'h40, 1'b0, "R7 set Y=0");
    send_byte(8'h01, 1'b1, "R6 last column");
    send_byte(8'h80, 1'b1, "R6 bank step");

    send_byte(8'hD3, 1'b0, "R7 set X=83");
    send_byte(8'h45, 1'b0, "R7 set Y=5");
    send_byte(8'hFE, 1'b1, "R6 last location");
    send_byte(8'h7F, 1'b1, "R6 wrap to 0");

    send_byte(8'hE4, 1'b0, "R7 X=100 ignored");
    send_byte(8'h47, 1'b0, "R7 Y=7 ignored");
    send_byte(8'h96, 1'b1, "R7 address kept");

    send_bits(8'hFF, 5, 1'b1, 1'b1, "R4 partial");
    step(2);
    lcd_cen_n = 1'b1; step(4);
    for (int k = 0; k < 10; k++) begin
      lcd_sdin = k[0]; lcd_sclk = 1'b1; step(3); lcd_sclk = 1'b0; step(3);
    end
    lcd_cen_n = 1'b0; step(4);
    send_byte(8'h69, 1'b1, "R4 restart at bit 7");

    send_bits(8'h55, 8, 1'b1, 1'b0, "R10 dc late low");
    send_bits(8'hAA, 8, 1'b0, 1'b1, "R10 dc late high");

    send_bits(8'hF0, 4, 1'b1, 1'b1, "R8 aborted");
    rst = 1'b1; step(2);
    rst = 1'b0; mx = 0; my = 0; step(2);
    send_byte(8'h5A, 1'b1, "R9 first byte after reset");
    send_byte(8'hC3, 1'b1, "R8 counter cleared");

    step(10);
    chk(q.size() == 0, "R3", "pending expectations", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    chk(1'b0, "R3", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule